// File: doc/BRIEF.md
# Buffered Synchronous Serial Shift Port

This block is an eight-bit synchronous serial port. Software selects receive or transmit with one control bit. It exchanges bytes through a single holding register that sits in front of a shift register. In receive mode, another device drives the shift clock line. On each rising edge of that clock, the port samples the data line. Once eight bits are in, the byte goes to the holding register and the interrupt is raised.

In transmit mode, the port acts as clock master. Each underflow strobe from an external timer inverts the shift clock, so one bit takes two underflows. Data changes only on the falling edge of the clock. When software writes the next byte before the current one finishes, the port reloads it on the eighth rising edge and the stream continues without a gap. When nothing is pending, the clock parks high and the data line keeps the last bit sent.

Both pad lines are open drain: the block only pulls them low, so several ports can share one two-wire bus. Pad inputs are brought into the system clock domain through a two-stage synchronizer.

Top module: `sser_port`

## Requirements
- R1: After reset, both pad enables are 0 (lines released), the mode is receive, the interrupt output is 0 and the status register reads 0x00.
- R2: In receive mode (status bit 0 = 0), the port samples the data line on each synchronized rising edge of the clock line, most significant bit first. After eight edges, the byte is readable at address 0 and the interrupt is set.
- R3: In transmit mode (bit 0 of a write to address 1 = 1), each underflow strobe while a byte is in flight inverts the shift clock. One bit is sent per two strobes.
- R4: Transmission starts only when a byte is pending and the timer-continuous input is 1. With that input at 0, strobes leave the clock line high and the pending bit (status bit 2) stays set.
- R5: The data line changes only on a falling edge of the shift clock. It carries the byte's bits most significant first, and each bit is held until the next falling edge.
- R6: On the eighth rising edge of a byte, the interrupt is set. If a byte is pending, it is loaded at once, the pending bit clears, and the next strobe is the falling edge carrying its first bit.
- R7: If no byte is pending after the eighth rising edge, the clock line stays high and the data line keeps the last bit sent, whatever strobes follow.
- R8: The pads are open drain. An enable of 1 pulls the line low. In receive mode, both enables are 0.
- R9: Address 1 reads mode in bit 0, the interrupt flag in bit 1 and the pending flag in bit 2. Reading address 1 clears the interrupt flag. A write to address 0 sets the pending flag.
- R10: In receive mode, underflow strobes have no effect on the pad enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (status read clears interrupt) |
| bus_addr | input | 1 | 0 = data holding register, 1 = control/status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| tmr_uflow | input | 1 | One-cycle timer underflow strobe |
| tmr_cont | input | 1 | Timer running in continuous mode |
| clk_pad_in | input | 1 | Level of the shared shift clock line |
| dat_pad_in | input | 1 | Level of the shared serial data line |
| clk_pad_oe | output | 1 | Pull shift clock line low |
| dat_pad_oe | output | 1 | Pull serial data line low |
| irq | output | 1 | Byte complete interrupt |

## Verification
Register writes appear on the status read path one cycle later. A transmit start happens on the edge after the data write, and each pad enable follows its underflow strobe by exactly one edge. A change on the receive clock pad reaches the shift register on the third edge: two synchronizer stages plus the edge-detect flop. The bench therefore sets the data line three cycles before the clock edge and reads the byte four cycles after the last one. The bench samples one time unit after the edge that is expected to update an output, and checks each transmitted bit both after its falling strobe and after the following rising strobe.

// File: rtl/sser_pkg.sv
package sser_pkg;

    parameter int unsigned SER_W = 8;

    typedef enum logic {
        MODE_RX = 1'b0,
        MODE_TX = 1'b1
    } ser_mode_e;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic      pend;
        logic      irq;
        ser_mode_e mode;
    } ser_status_t;

    function automatic logic [7:0] pack_status(ser_status_t s);
        return {5'b0, s};
    endfunction

endpackage

// File: rtl/sser_sync.sv
module sser_sync #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VAL;
                else     stg <= d_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) stg <= {STAGES{RST_VAL}};
                else     stg <= {stg[STAGES-2:0], d_in};
            end
        end
    endgenerate

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/sser_rx.sv
module sser_rx #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         cnt_s,
    input  logic         sp_s,
    output logic         byte_done,
    output logic [W-1:0] rx_byte
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          cnt_d;
    logic [W-1:0]  sh;
    logic [CW-1:0] bitcnt;
    logic          rise;

    assign rise      = en & cnt_s & ~cnt_d;
    assign byte_done = rise & (bitcnt == LAST);
    assign rx_byte   = {sh[W-2:0], sp_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_d  <= 1'b1;
            sh     <= '0;
            bitcnt <= '0;
        end else begin
            cnt_d <= cnt_s;
            if (!en) begin
                bitcnt <= '0;
            end else if (rise) begin
                sh     <= rx_byte;
                bitcnt <= byte_done ? '0 : bitcnt + 1'b1;
            end
        end
    end

    // R2: a completed byte always leaves the bit counter at zero
    assert_rx_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> (bitcnt == '0));
endmodule

// File: rtl/sser_tx.sv
module sser_tx #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         uflow,
    input  logic         tmr_cont,
    input  logic         pend,
    input  logic [W-1:0] hold_byte,
    output logic         load,
    output logic         byte_done,
    output logic         clk_out,
    output logic         sp_out
);
    localparam int unsigned CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic          active;
    logic [W-1:0]  sh;
    logic [CW-1:0] bitcnt;
    logic          start, fall_evt, rise_evt;

    assign start     = en & ~active & pend & tmr_cont;
    assign fall_evt  = en & active & uflow & clk_out;
    assign rise_evt  = en & active & uflow & ~clk_out;
    assign byte_done = rise_evt & (bitcnt == LAST);
    assign load      = start | (byte_done & pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            clk_out <= 1'b1;
            sp_out  <= 1'b1;
            sh      <= '0;
            bitcnt  <= '0;
        end else if (!en) begin
            active  <= 1'b0;
            clk_out <= 1'b1;
            bitcnt  <= '0;
        end else begin
            if (start) begin
                active <= 1'b1;
                sh     <= hold_byte;
                bitcnt <= '0;
            end
            if (fall_evt) begin
                clk_out <= 1'b0;
                sp_out  <= sh[W-1];
                sh      <= {sh[W-2:0], 1'b0};
            end
            if (rise_evt) begin
                clk_out <= 1'b1;
                if (byte_done) begin
                    bitcnt <= '0;
                    if (pend) sh <= hold_byte;
                    else      active <= 1'b0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    // R3: every strobe during a byte inverts the shift clock
    assert_clk_toggle_R3: assert property (@(posedge clk) disable iff (rst)
        (en && active && uflow) |=> (clk_out != $past(clk_out)));
    // R4: a transfer only begins with data pending and the timer continuous
    assert_start_gate_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> ($past(pend) && $past(tmr_cont)));
    // R5: the data line moves only together with a falling clock
    assert_sp_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (sp_out != $past(sp_out)) |-> $fell(clk_out));
    // R7: idle means the clock is parked high
    assert_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
        !active |-> clk_out);
    // R10: outside transmit mode the clock is released
    assert_rx_release_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> clk_out);
endmodule

// File: rtl/sser_port.sv
module sser_port
    import sser_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tmr_uflow,
    input  logic       tmr_cont,
    input  logic       clk_pad_in,
    input  logic       dat_pad_in,
    output logic       clk_pad_oe,
    output logic       dat_pad_oe,
    output logic       irq
);
    localparam int unsigned SYNC_STAGES = 2;

    ser_mode_e        mode_q;
    logic [SER_W-1:0] hold_q;
    logic             pend_q, irq_q;
    logic             wr_data, wr_ctrl, rd_stat;
    logic [1:0]       pads_s;
    logic             rx_done, tx_done, tx_load, tx_clk, tx_sp, is_tx;
    logic [SER_W-1:0] rx_byte;
    ser_status_t      st;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[7:1];
    assign wr_data = bus_wr & (reg_sel_e'(bus_addr) == SEL_DATA);
    assign wr_ctrl = bus_wr & (reg_sel_e'(bus_addr) == SEL_CTRL);
    assign rd_stat = bus_rd & (reg_sel_e'(bus_addr) == SEL_CTRL);
    assign is_tx   = (mode_q == MODE_TX);

    sser_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({clk_pad_in, dat_pad_in}),
        .d_out (pads_s)
    );

    sser_rx #(.W(SER_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .en        (!is_tx),
        .cnt_s     (pads_s[1]),
        .sp_s      (pads_s[0]),
        .byte_done (rx_done),
        .rx_byte   (rx_byte)
    );

    sser_tx #(.W(SER_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .en        (is_tx),
        .uflow     (tmr_uflow),
        .tmr_cont  (tmr_cont),
        .pend      (pend_q),
        .hold_byte (hold_q),
        .load      (tx_load),
        .byte_done (tx_done),
        .clk_out   (tx_clk),
        .sp_out    (tx_sp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RX;
            hold_q <= '0;
            pend_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ctrl) mode_q <= ser_mode_e'(bus_wdata[0]);
            if (wr_data)      hold_q <= bus_wdata;
            else if (rx_done) hold_q <= rx_byte;
            pend_q <= wr_data | (pend_q & ~tx_load);
            irq_q  <= rx_done | tx_done | (irq_q & ~rd_stat);
        end
    end

    assign st.pend = pend_q;
    assign st.irq  = irq_q;
    assign st.mode = mode_q;

    assign bus_rdata  = (reg_sel_e'(bus_addr) == SEL_CTRL) ? pack_status(st) : hold_q;
    assign clk_pad_oe = is_tx & ~tx_clk;
    assign dat_pad_oe = is_tx & ~tx_sp;
    assign irq        = irq_q;

    // R2: a finished receive byte lands in the holding register with an interrupt
    assert_rx_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !wr_data) |=> (hold_q == $past(rx_byte) && irq_q));
    // R6: a finished transmit byte raises the interrupt
    assert_tx_irq_R6: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> irq_q);
    // R9: a status read without a new completion clears the interrupt
    assert_stat_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_stat && !rx_done && !tx_done) |=> !irq_q);
    // R6: a load always consumes the pending byte
    assert_load_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_load && !wr_data) |=> !pend_q);
endmodule

// File: tb/tb_sser_port.sv
module tb_sser_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       tmr_uflow = 1'b0, tmr_cont = 1'b1;
    logic       ext_cnt = 1'b1, ext_sp = 1'b1;
    logic       clk_pad_oe, dat_pad_oe, irq;
    logic       cnt_line, sp_line;
    int         n_tests = 0, n_fail = 0;
    bit         finished = 1'b0;

    assign cnt_line = ext_cnt & ~clk_pad_oe;
    assign sp_line  = ext_sp & ~dat_pad_oe;

    always #2.5 clk = ~clk;

    sser_port dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_uflow(tmr_uflow), .tmr_cont(tmr_cont),
        .clk_pad_in(cnt_line), .dat_pad_in(sp_line),
        .clk_pad_oe(clk_pad_oe), .dat_pad_oe(dat_pad_oe), .irq(irq)
    );

    // mode bit, byte
    localparam logic [8:0] VEC [6] = '{
        {1'b1, 8'hA5}, {1'b0, 8'h3C}, {1'b1, 8'h01},
        {1'b0, 8'hFE}, {1'b1, 8'h80}, {1'b0, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic uf();
        tmr_uflow = 1'b1;
        tick();
        tmr_uflow = 1'b0;
        tick();
    endtask

    // shift out one byte; data already loaded (do_start adds the start cycle)
    task automatic tx_run(input logic [7:0] b, input bit do_start);
        if (do_start) tick();
        for (int i = 7; i >= 0; i--) begin
            tmr_uflow = 1'b1; tick(); tmr_uflow = 1'b0;
            chk("R3 clock low after strobe", cnt_line, 1'b0);
            chk("R5 bit on falling edge", sp_line, b[i]);
            tick();
            tmr_uflow = 1'b1; tick(); tmr_uflow = 1'b0;
            chk("R3 clock high after strobe", cnt_line, 1'b1);
            chk("R5 bit held over rising edge", sp_line, b[i]);
            tick();
        end
        chk("R6 irq after eighth edge", irq, 1'b1);
    endtask

    task automatic rx_run(input logic [7:0] b);
        logic [7:0] d;
        for (int i = 7; i >= 0; i--) begin
            ext_sp = b[i]; tick(3);
            ext_cnt = 1'b0; tick(3);
            ext_cnt = 1'b1; tick(4);
            chk("R8 no pull in receive", {clk_pad_oe, dat_pad_oe}, 2'b00);
        end
        ext_sp = 1'b1;
        chk("R2 irq after byte", irq, 1'b1);
        bus_read(1'b0, d);
        chk("R2 received byte", d, b);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 pad enables", {clk_pad_oe, dat_pad_oe}, 2'b00);
        chk("R1 irq", irq, 1'b0);
        bus_read(1'b1, d);
        chk("R1 status", d, 8'h00);

        // vector table
        for (int v = 0; v < 6; v++) begin
            bus_write(1'b1, {7'b0, VEC[v][8]});
            if (VEC[v][8]) begin
                bus_write(1'b0, VEC[v][7:0]);
                tx_run(VEC[v][7:0], 1'b1);
                chk("R7 line holds last bit", sp_line, VEC[v][0]);
            end else begin
                rx_run(VEC[v][7:0]);
            end
            bus_read(1'b1, d);
            chk("R9 status irq bit and mode", d[1:0], {1'b1, VEC[v][8]});
            chk("R9 irq cleared by status read", irq, 1'b0);
        end

        // R10: strobes in receive mode do nothing
        bus_write(1'b1, 8'h00);
        uf(); uf(); uf();
        chk("R10 clock released in receive", cnt_line, 1'b1);
        chk("R10 no pull in receive", {clk_pad_oe, dat_pad_oe}, 2'b00);

        // R4: no start while timer is not continuous
        bus_write(1'b1, 8'h01);
        tmr_cont = 1'b0;
        bus_write(1'b0, 8'h5A);
        uf(); uf(); uf();
        chk("R4 clock idle without continuous timer", cnt_line, 1'b1);
        bus_read(1'b1, d);
        chk("R4 pending stays set", d[2:0], 3'b101);
        tmr_cont = 1'b1;
        tx_run(8'h5A, 1'b1);
        bus_read(1'b1, d);

        // R6: gapless streaming
        bus_write(1'b0, 8'hC3);
        tick();
        bus_write(1'b0, 8'h96);
        bus_read(1'b1, d);
        chk("R9 pending after data write", d[2], 1'b1);
        tx_run(8'hC3, 1'b0);
        bus_read(1'b1, d);
        chk("R6 reload consumed pending", d[2], 1'b0);
        tx_run(8'h96, 1'b0);
        // R7: nothing pending, line parks
        uf(); uf(); uf();
        chk("R7 clock parked high", cnt_line, 1'b1);
        chk("R7 data holds last bit", sp_line, 1'b0);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule